// File: doc/BRIEF.md
# GPIO Output Register Set/Clear Bank

This block holds the output data bytes for a group of general-purpose output ports and drives each byte onto a parallel pin vector. Software reaches every port through three byte-wide windows: a data window that can be read and written, a set window and a clear window. The set window forces output bits high wherever a one is written. The clear window forces bits low wherever a zero is written. Both windows leave all other bits alone, so a single write changes chosen pins without a read-modify-write sequence. Both windows read back as zero.

Each port has an implemented-bit mask fixed by a parameter. Bits outside the mask do not exist: they always read and drive 0, and no write changes them. The bus is a simple synchronous byte interface with address, write data, write enable, read enable and registered read data.

Top module: `gpio_outbank`

## Requirements
- R1: While `rst_n` is low, every output data byte is cleared to 0x00, so `port_out` is all zeros and `rd_data` is 0x00.
- R2: A write with `addr[5:4]` = 2'b00 and `addr[3:0]` = port index p (p < NPORTS) replaces port p's output byte with `wdata` under that port's mask, effective at the sampling edge. A read at the same address returns the current masked byte.
- R3: A write with `addr[5:4]` = 2'b01 to port p sets each output bit where `wdata` holds a 1. Bits where `wdata` holds a 0 keep their value.
- R4: A write with `addr[5:4]` = 2'b10 to port p clears each output bit where `wdata` holds a 0. Bits where `wdata` holds a 1 keep their value.
- R5: A read of any set window (2'b01) or clear window (2'b10) returns 0x00.
- R6: Bits of port p outside byte p of `PORT_MASK` read as 0, drive 0 on `port_out`, and ignore data, set and clear writes.
- R7: Addresses with `addr[5:4]` = 2'b11, or with `addr[3:0]` >= NPORTS, are unmapped. Reads of them return 0x00 and writes to them change no output.
- R8: `rd_data` presents the value addressed in the cycle where `rd_en` was sampled high, one clock later. After any edge where `rd_en` is low, `rd_data` is 0x00. A write to one port never alters another port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 6 | Window select in [5:4], port index in [3:0] |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| rd_data | output | 8 | Registered read data |
| port_out | output | NPORTS*8 | Output bytes, port p at bits [8p+7:8p] |

## Verification
The bench builds the bank with six ports whose masks are 0xFF, 0x0F, 0x7F, 0xFF, 0x3F and 0xFF. These masks place full, half and odd partial ports side by side, so set and clear writes that reach unimplemented bits can be checked against both the pins and readback. With six ports, indices 6 to 15 fall inside the port field but stay unmapped, which exercises the range guard as well as the unused window code.

// File: rtl/gpio_outbank.sv
module gpio_outbank #(
  parameter int NPORTS = 6,
  parameter logic [127:0] PORT_MASK = 128'h0000_0000_0000_0000_0000_FF3F_FF7F_0FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic [NPORTS*8-1:0] port_out
);
  localparam logic [1:0] WIN_DATA = 2'b00;
  localparam logic [1:0] WIN_SET  = 2'b01;
  localparam logic [1:0] WIN_CLR  = 2'b10;

  wire [1:0] win = addr[5:4];
  wire [3:0] idx = addr[3:0];
  wire       in_range = int'(idx) < NPORTS;

  logic [7:0] rd_next;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam logic [7:0] M = PORT_MASK[p*8 +: 8];
    logic [7:0] odr;
    wire hit = wr_en && in_range && (idx == 4'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) odr <= 8'h00;
      else if (hit) begin
        case (win)
          WIN_DATA: odr <= wdata & M;
          WIN_SET:  odr <= odr | (wdata & M);
          WIN_CLR:  odr <= odr & wdata;
          default:  odr <= odr;
        endcase
      end
    end

    assign port_out[p*8 +: 8] = odr;
  end

  always_comb begin
    rd_next = 8'h00;
    for (int p = 0; p < NPORTS; p++)
      if (rd_en && in_range && win == WIN_DATA && idx == 4'(p))
        rd_next = port_out[p*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= 8'h00;
    else        rd_data <= rd_next;
  end
endmodule

// File: rtl/gpio_outbank_chk.sv
module gpio_outbank_chk #(
  parameter int NPORTS = 6,
  parameter logic [127:0] PORT_MASK = 128'h0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:0]        addr,
  input logic [7:0]        wdata,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic [NPORTS*8-1:0] port_out
);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (port_out == '0 && rd_data == 8'h00));

  assert_win_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr[5:4] == 2'b01 || addr[5:4] == 2'b10)) |=> rd_data == 8'h00);

  assert_unmapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr[5:4] == 2'b11 || int'(addr[3:0]) >= NPORTS)) |=> $stable(port_out));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(port_out));

  assert_rd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == 8'h00);

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    localparam logic [7:0] M = PORT_MASK[p*8 +: 8];

    assert_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == {2'b00, 4'(p)}) |=> port_out[p*8 +: 8] == ($past(wdata) & M));

    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == {2'b01, 4'(p)}) |=>
        port_out[p*8 +: 8] == ($past(port_out[p*8 +: 8]) | ($past(wdata) & M)));

    assert_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == {2'b10, 4'(p)}) |=>
        port_out[p*8 +: 8] == ($past(port_out[p*8 +: 8]) & $past(wdata)));

    assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (port_out[p*8 +: 8] & ~M) == 8'h00);

    assert_other_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[3:0] != 4'(p)) |=> $stable(port_out[p*8 +: 8]));
  end
endmodule

bind gpio_outbank gpio_outbank_chk #(.NPORTS(NPORTS), .PORT_MASK(PORT_MASK)) chk_i (.*);

// File: tb/gpio_outbank_test.sv
module gpio_outbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 6;
  localparam logic [127:0] MASKS = 128'h0000_0000_0000_0000_0000_FF3F_FF7F_0FFF;

  logic clk = 0;
  logic rst_n = 0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] rd_data;
  logic [NP*8-1:0] port_out;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [NP];

  gpio_outbank #(.NPORTS(NP), .PORT_MASK(MASKS)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .port_out(port_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mask_of(int p);
    return MASKS[p*8 +: 8];
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (int'(a[3:0]) < NP) begin
      case (a[5:4])
        2'b00: model[a[3:0]] = d & mask_of(int'(a[3:0]));
        2'b01: model[a[3:0]] = model[a[3:0]] | (d & mask_of(int'(a[3:0])));
        2'b10: model[a[3:0]] = model[a[3:0]] & d;
        default: ;
      endcase
    end
  endtask

  task automatic bus_read(logic [5:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic check_all_pins(string tag);
    for (int p = 0; p < NP; p++) check(tag, port_out[p*8 +: 8], model[p]);
  endtask

  task automatic t_reset();
    for (int p = 0; p < NP; p++) model[p] = 8'h00;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 port_out after reset", port_out[7:0] | port_out[47:40], 8'h00);
    check("R1 rd_data in reset", rd_data, 8'h00);
    rst_n = 1;
  endtask

  task automatic t_data_write();
    logic [7:0] v;
    bus_write(6'h00, 8'hA5);
    check("R2 pins port0", port_out[7:0], 8'hA5);
    bus_read(6'h00, v);
    check("R2 readback port0", v, 8'hA5);
    bus_write(6'h03, 8'h3C);
    bus_read(6'h03, v);
    check("R2 readback port3", v, 8'h3C);
    check_all_pins("R8 no cross-port effect");
  endtask

  task automatic t_set();
    logic [7:0] v;
    bus_write(6'h05, 8'h11);
    bus_write(6'h15, 8'h82);
    check("R3 set ones port5", port_out[47:40], 8'h93);
    bus_write(6'h15, 8'h00);
    bus_read(6'h05, v);
    check("R3 zero set leaves", v, 8'h93);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    bus_write(6'h03, 8'hFF);
    bus_write(6'h23, 8'h5A);
    check("R4 zeros clear port3", port_out[31:24], 8'h5A);
    bus_write(6'h23, 8'hFF);
    bus_read(6'h03, v);
    check("R4 ones leave port3", v, 8'h5A);
  endtask

  task automatic t_rd_zero();
    logic [7:0] v;
    bus_read(6'h13, v);
    check("R5 set window reads zero", v, 8'h00);
    bus_read(6'h23, v);
    check("R5 clear window reads zero", v, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    bus_write(6'h01, 8'hFF);
    check("R6 port1 data masked", port_out[15:8], 8'h0F);
    bus_write(6'h12, 8'h81);
    bus_read(6'h02, v);
    check("R6 port2 set masked", v, 8'h01);
    bus_write(6'h04, 8'h3F);
    bus_write(6'h24, 8'hF0);
    check("R6 port4 clear partial", port_out[39:32], 8'h30);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    bus_write(6'h06, 8'hFF);
    bus_write(6'h36, 8'hFF);
    bus_write(6'h30, 8'h00);
    bus_write(6'h1F, 8'hFF);
    check_all_pins("R7 unmapped write no change");
    bus_read(6'h30, v);
    check("R7 unmapped window reads zero", v, 8'h00);
    bus_read(6'h07, v);
    check("R7 out-of-range port reads zero", v, 8'h00);
  endtask

  task automatic t_timing();
    logic [7:0] v;
    bus_read(6'h00, v);
    check("R8 read data after rd_en", v, model[0]);
    @(negedge clk);
    check("R8 rd_data idle zero", rd_data, 8'h00);
  endtask

  initial begin
    t_reset();
    t_data_write();
    t_set();
    t_clear();
    t_rd_zero();
    t_mask();
    t_unmapped();
    t_timing();
    check_all_pins("R2 final pin state");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule